// File: doc/BRIEF.md
# Configurable Three-Port Parallel I/O Controller

This block gives a host bus three byte-wide parallel ports, A, B and C, plus a control register that can only be written. The host reaches them through an 8-bit data bus qualified by an active-low select, an active-low read strobe, an active-low write strobe and a two-bit address. Port C is handled as two independent four-bit halves. Each half has its own direction, and every single bit of port C can also be forced high or low with one control write.

The top bit of a control write picks between two actions. A configuration word sets the direction of ports A and B and of the two port C halves, and it clears every output latch. A bit command updates exactly one port C latch bit and leaves the directions alone. Only plain input/output operation is provided. Pads are modelled as separate input, output and output-enable vectors, so the block can sit behind any pad ring.

Top module: `pario_ctl`

## Requirements
- R1: While `rst` is high and after it falls, every output-enable is 0 (all ports are inputs) and every output latch holds 0x00.
- R2: A write with `sel_n`=0 and `wr_n`=0 takes effect at that clock edge. Address 0 loads port A, address 1 loads port B and address 2 loads port C, and the value appears on the matching `*_out` after that edge.
- R3: A control write (address 3) with bit 7 = 1 is a configuration word. Bit 4 sets the direction of port A, bit 1 the direction of port B, bit 3 the direction of port C bits 7:4, and bit 0 the direction of port C bits 3:0. A direction bit of 1 means input (output-enable 0) and 0 means output (output-enable 1).
- R4: Configuration word 0x92 gives A and B as inputs and all of C as output. 0x90 gives only A as input. 0x8B gives A as output and B and C as inputs.
- R5: Bits 6:5 and bit 2 of a configuration word have no effect. Any value in those bits gives the same directions and port behaviour as zeros there.
- R6: Every configuration word clears the latches of ports A, B and C to 0x00.
- R7: A control write with bit 7 = 0 is a bit command. Bits 3:1 give the port C bit index (0 to 7), and bit 0 is the new value of that bit. Only that latch bit changes, and bits 6:4 are ignored.
- R8: A bit command changes no direction and no latch of ports A or B.
- R9: A read (`sel_n`=0, `rd_n`=0) of ports A, B or C returns the pin input on bits whose section is an input and the latch on bits whose section is an output. On port C this is decided for each half separately.
- R10: A read at address 3 returns 0x00, and `rdata` is 0x00 whenever no read is in progress.
- R11: Nothing is written when `sel_n` is high or `wr_n` is high, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low block select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select: 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while the read is active |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A latch driven toward the pins |
| pa_oe | output | 8 | Port A per-pin output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B latch driven toward the pins |
| pb_oe | output | 8 | Port B per-pin output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C latch driven toward the pins |
| pc_oe | output | 8 | Port C per-pin output enables |

## Verification
The bench walks all sixteen direction combinations, each with all eight junk patterns in the mode fields. A design that decoded a mode field, or swapped the port B and upper-C direction bits, would show wrong enables or wrong read data. Every port C index is set and then cleared under junk in bits 6:4. A wrong index decode, or a mask that touched neighbouring bits, would leave stray bits in `pc_out`. Read-back uses pin patterns that differ from the latches, so a mux keyed to the whole port rather than each half of port C returns the wrong nibble. The bench also writes with the select or the write strobe held inactive, and a design that ignored either one would corrupt a latch.

// File: rtl/pario_pkg.sv
package pario_pkg;

   typedef enum logic [1:0] {
      SEL_PA  = 2'b00,
      SEL_PB  = 2'b01,
      SEL_PC  = 2'b10,
      SEL_CTL = 2'b11
   } pario_sel_e;

   // direction of each section; 1 = input
   typedef struct packed {
      logic a;
      logic b;
      logic cu;
      logic cl;
   } pario_dir_t;

   localparam pario_dir_t DIR_ALL_IN = '{a: 1'b1, b: 1'b1, cu: 1'b1, cl: 1'b1};

   // control word field positions (behaviour depends on these)
   localparam int CW_KIND   = 7;
   localparam int CW_DIR_A  = 4;
   localparam int CW_DIR_CU = 3;
   localparam int CW_DIR_B  = 1;
   localparam int CW_DIR_CL = 0;
   localparam int CW_IDX_LO = 1;
   localparam int CW_VAL    = 0;

endpackage

// File: rtl/pario_cfg.sv
module pario_cfg
   import pario_pkg::*;
#(
   parameter int PORT_W = 8,
   localparam int IDX_W = $clog2(PORT_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctl_wr,
   input  logic [7:0]        wdata,
   output pario_dir_t        dir,
   output logic              cfg_load,
   output logic              bit_cmd,
   output logic [PORT_W-1:0] bit_mask,
   output logic              bit_val
);

   pario_dir_t        dir_q;
   logic [IDX_W-1:0]  idx;
   logic              unused_mode_bits;

   assign cfg_load = ctl_wr &  wdata[CW_KIND];
   assign bit_cmd  = ctl_wr & ~wdata[CW_KIND];
   assign idx      = wdata[CW_IDX_LO +: IDX_W];
   assign bit_val  = wdata[CW_VAL];

   // mode fields are accepted and have no effect: only mode 0 exists
   assign unused_mode_bits = ^{wdata[6:5], wdata[2]};

   always_comb begin
      for (int k = 0; k < PORT_W; k++) begin
         bit_mask[k] = (idx == IDX_W'(k));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q <= DIR_ALL_IN;
      end else if (cfg_load) begin
         dir_q.a  <= wdata[CW_DIR_A];
         dir_q.b  <= wdata[CW_DIR_B];
         dir_q.cu <= wdata[CW_DIR_CU];
         dir_q.cl <= wdata[CW_DIR_CL];
      end
   end

   assign dir = dir_q;

endmodule

// File: rtl/pario_lane.sv
module pario_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         dir_in,
   input  logic [W-1:0] wr_mask,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_val
);

   logic [W-1:0] latch_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         latch_q <= '0;
      end else begin
         latch_q <= (latch_q & ~wr_mask) | (wr_data & wr_mask);
      end
   end

   assign pin_out = latch_q;
   assign pin_oe  = {W{~dir_in}};
   assign rd_val  = dir_in ? pin_in : latch_q;

endmodule

// File: rtl/pario_ctl.sv
module pario_ctl
   import pario_pkg::*;
#(
   parameter int         PORT_W     = 8,
   parameter logic [7:0] CTRL_RDATA = 8'h00,
   parameter logic [7:0] IDLE_RDATA = 8'h00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [PORT_W-1:0] pa_in,
   output logic [PORT_W-1:0] pa_out,
   output logic [PORT_W-1:0] pa_oe,
   input  logic [PORT_W-1:0] pb_in,
   output logic [PORT_W-1:0] pb_out,
   output logic [PORT_W-1:0] pb_oe,
   input  logic [PORT_W-1:0] pc_in,
   output logic [PORT_W-1:0] pc_out,
   output logic [PORT_W-1:0] pc_oe
);

   localparam int NIB_W = PORT_W / 2;

   if (PORT_W != 8) begin : g_bad_port_w
      $error("pario_ctl: PORT_W must equal the 8-bit bus width");
   end

   logic              wr_hit, rd_hit;
   logic              wr_pa, wr_pb, wr_pc, wr_ctl;
   pario_dir_t        dir;
   logic              cfg_load, bit_cmd, bit_val;
   logic [PORT_W-1:0] bit_mask;
   logic [PORT_W-1:0] pa_rd, pb_rd, pc_rd;
   logic [PORT_W-1:0] pc_mask, pc_data;

   assign wr_hit = ~sel_n & ~wr_n;
   assign rd_hit = ~sel_n & ~rd_n;
   assign wr_pa  = wr_hit && (addr == SEL_PA);
   assign wr_pb  = wr_hit && (addr == SEL_PB);
   assign wr_pc  = wr_hit && (addr == SEL_PC);
   assign wr_ctl = wr_hit && (addr == SEL_CTL);

   pario_cfg #(.PORT_W(PORT_W)) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .ctl_wr   (wr_ctl),
      .wdata    (wdata),
      .dir      (dir),
      .cfg_load (cfg_load),
      .bit_cmd  (bit_cmd),
      .bit_mask (bit_mask),
      .bit_val  (bit_val)
   );

   pario_lane #(.W(PORT_W)) u_lane_a (
      .clk (clk), .rst (rst), .clr (cfg_load), .dir_in (dir.a),
      .wr_mask ({PORT_W{wr_pa}}), .wr_data (wdata[PORT_W-1:0]),
      .pin_in (pa_in), .pin_out (pa_out), .pin_oe (pa_oe), .rd_val (pa_rd)
   );

   pario_lane #(.W(PORT_W)) u_lane_b (
      .clk (clk), .rst (rst), .clr (cfg_load), .dir_in (dir.b),
      .wr_mask ({PORT_W{wr_pb}}), .wr_data (wdata[PORT_W-1:0]),
      .pin_in (pb_in), .pin_out (pb_out), .pin_oe (pb_oe), .rd_val (pb_rd)
   );

   // port C: whole-byte write or a single-bit command
   assign pc_mask = wr_pc ? {PORT_W{1'b1}} : (bit_cmd ? bit_mask : '0);
   assign pc_data = wr_pc ? wdata[PORT_W-1:0] : {PORT_W{bit_val}};

   for (genvar h = 0; h < 2; h++) begin : g_pc_half
      pario_lane #(.W(NIB_W)) u_lane_c (
         .clk     (clk),
         .rst     (rst),
         .clr     (cfg_load),
         .dir_in  ((h == 1) ? dir.cu : dir.cl),
         .wr_mask (pc_mask[h*NIB_W +: NIB_W]),
         .wr_data (pc_data[h*NIB_W +: NIB_W]),
         .pin_in  (pc_in[h*NIB_W +: NIB_W]),
         .pin_out (pc_out[h*NIB_W +: NIB_W]),
         .pin_oe  (pc_oe[h*NIB_W +: NIB_W]),
         .rd_val  (pc_rd[h*NIB_W +: NIB_W])
      );
   end

   always_comb begin
      rdata = IDLE_RDATA;
      if (rd_hit) begin
         case (addr)
            SEL_PA:  rdata = pa_rd;
            SEL_PB:  rdata = pb_rd;
            SEL_PC:  rdata = pc_rd;
            default: rdata = CTRL_RDATA;
         endcase
      end
   end

endmodule

// File: rtl/pario_ctl_chk.sv
module pario_ctl_chk #(
   parameter int PORT_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              sel_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic [1:0]        addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic [PORT_W-1:0] pa_in,
   input logic [PORT_W-1:0] pa_out,
   input logic [PORT_W-1:0] pa_oe,
   input logic [PORT_W-1:0] pb_in,
   input logic [PORT_W-1:0] pb_out,
   input logic [PORT_W-1:0] pb_oe,
   input logic [PORT_W-1:0] pc_in,
   input logic [PORT_W-1:0] pc_out,
   input logic [PORT_W-1:0] pc_oe
);

   logic wr_act, ctl_wr;
   logic [PORT_W-1:0] one;
   assign wr_act = !sel_n && !wr_n;
   assign ctl_wr = wr_act && (addr == 2'b11);
   assign one    = PORT_W'(1);

   p_reset_inputs_r1: assert property (@(posedge clk)
      $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pa_out == '0));

   p_port_a_load_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_act && addr == 2'b00) |=> (pa_out == $past(wdata)));

   p_cfg_dir_a_r3: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && wdata[7]) |=> (pa_oe == {PORT_W{~$past(wdata[4])}}));

   p_cfg_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

   p_bit_cmd_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && !wdata[7]) |=>
         (pc_out == (($past(pc_out) & ~(one << $past(wdata[3:1]))) |
                     (PORT_W'($past(wdata[0])) << $past(wdata[3:1])))));

   p_bit_cmd_keeps_dir_r8: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && !wdata[7]) |=>
         ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pa_out) && $stable(pb_out)));

   p_ctl_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
      (!sel_n && !rd_n && addr == 2'b11) |-> (rdata == 8'h00));

   p_no_write_r11: assert property (@(posedge clk) disable iff (rst)
      !wr_act |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pc_oe)));

endmodule

bind pario_ctl pario_ctl_chk #(.PORT_W(PORT_W)) u_pario_chk (.*);

// File: tb/pario_ctl_tb_top.sv
module pario_ctl_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       sel_n, rd_n, wr_n;
   logic [1:0] addr;
   logic [7:0] wdata, rdata;
   logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe, pc_in, pc_out, pc_oe;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model of architectural state
   logic [7:0] m_la, m_lb, m_lc;
   logic       m_da, m_db, m_dcu, m_dcl;

   always #4 clk = ~clk;

   pario_ctl dut_i (
      .clk (clk), .rst (rst), .sel_n (sel_n), .rd_n (rd_n), .wr_n (wr_n),
      .addr (addr), .wdata (wdata), .rdata (rdata),
      .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
      .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
      .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_la = 0; m_lb = 0; m_lc = 0;
      m_da = 1; m_db = 1; m_dcu = 1; m_dcl = 1;
   endtask

   task automatic model_wr(input logic [1:0] a, input logic [7:0] d);
      case (a)
         2'd0: m_la = d;
         2'd1: m_lb = d;
         2'd2: m_lc = d;
         default:
            if (d[7]) begin
               m_da = d[4]; m_dcu = d[3]; m_db = d[1]; m_dcl = d[0];
               m_la = 0; m_lb = 0; m_lc = 0;
            end else begin
               m_lc[d[3:1]] = d[0];
            end
      endcase
   endtask

   // bus write lasting one clock; outputs settle before the next negedge
   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d,
                         input logic s_n = 1'b0, input logic w_n = 1'b0);
      @(negedge clk);
      sel_n = s_n; wr_n = w_n; addr = a; wdata = d;
      @(negedge clk);
      sel_n = 1'b1; wr_n = 1'b1; wdata = 8'h00;
      if (!s_n && !w_n) model_wr(a, d);
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      sel_n = 1'b0; rd_n = 1'b0; addr = a;
      #1 d = rdata;
      sel_n = 1'b1; rd_n = 1'b1;
   endtask

   function automatic logic [7:0] rd_exp(input logic dir, input logic [7:0] pin, input logic [7:0] lat);
      return dir ? pin : lat;
   endfunction

   task automatic check_state(input string tag);
      logic [7:0] r;
      chk({tag, " R3 pa_oe"}, pa_oe, {8{~m_da}});
      chk({tag, " R3 pb_oe"}, pb_oe, {8{~m_db}});
      chk({tag, " R3 pc_oe"}, pc_oe, {{4{~m_dcu}}, {4{~m_dcl}}});
      chk({tag, " R2 pa_out"}, pa_out, m_la);
      chk({tag, " R2 pb_out"}, pb_out, m_lb);
      chk({tag, " R2 pc_out"}, pc_out, m_lc);
      bus_rd(2'd0, r); chk({tag, " R9 read A"}, r, rd_exp(m_da, pa_in, m_la));
      bus_rd(2'd1, r); chk({tag, " R9 read B"}, r, rd_exp(m_db, pb_in, m_lb));
      bus_rd(2'd2, r);
      chk({tag, " R9 read C"}, r, {rd_exp(m_dcu, pc_in, m_lc)[7:4], rd_exp(m_dcl, pc_in, m_lc)[3:0]});
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] r;
      rst = 1'b1; sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 2'd0; wdata = 8'h00;
      pa_in = 8'hC3; pb_in = 8'h5A; pc_in = 8'h96;
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", pa_oe | pb_oe | pc_oe, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      check_state("R1 after reset");

      // R2 basic loads while all outputs
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd0, 8'hA5); bus_wr(2'd1, 8'h3C); bus_wr(2'd2, 8'hE1);
      check_state("R2 loads");

      // R4 named words
      bus_wr(2'd3, 8'h92); check_state("R4 0x92");
      chk("R4 0x92 dirs", {pa_oe[0], pb_oe[0], pc_oe[7], pc_oe[0]}, 8'h03);
      bus_wr(2'd3, 8'h90); check_state("R4 0x90");
      chk("R4 0x90 dirs", {pa_oe[0], pb_oe[0], pc_oe[7], pc_oe[0]}, 8'h07);
      bus_wr(2'd3, 8'h8B); check_state("R4 0x8B");
      chk("R4 0x8B dirs", {pa_oe[0], pb_oe[0], pc_oe[7], pc_oe[0]}, 8'h08);

      // R3 R5 R6 R9: all direction sets x all mode-field junk
      for (int dsel = 0; dsel < 16; dsel++) begin
         for (int junk = 0; junk < 8; junk++) begin
            logic [7:0] cw;
            cw = 8'h80 | {1'b0, junk[2:1], dsel[3], dsel[2], junk[0], dsel[1], dsel[0]};
            pa_in = 8'(dsel * 17 + junk); pb_in = ~pa_in; pc_in = 8'(8'h69 ^ (junk << 4) ^ dsel);
            bus_wr(2'd0, 8'h77); bus_wr(2'd2, 8'hF0);
            bus_wr(2'd3, cw);
            check_state("R5 R6 sweep cfg");
            bus_wr(2'd0, 8'(dsel * 13 + 1)); bus_wr(2'd1, 8'(junk * 29 + 3)); bus_wr(2'd2, 8'h5C ^ 8'(dsel));
            check_state("R3 R9 sweep data");
         end
      end

      // R7 R8: every port C bit set then cleared, junk in bits 6:4
      bus_wr(2'd3, 8'h92);
      bus_wr(2'd2, 8'h00);
      for (int idx = 0; idx < 8; idx++) begin
         for (int v = 1; v >= 0; v--) begin
            bus_wr(2'd3, {1'b0, 3'(idx + v * 5), 3'(idx), 1'(v)});
            chk("R7 bit command pc_out", pc_out, m_lc);
            check_state("R8 bit command");
         end
      end
      bus_wr(2'd2, 8'h5A);
      bus_wr(2'd3, 8'h0F);
      chk("R7 set bit7 keeps others", pc_out, 8'hDA);
      bus_wr(2'd3, 8'h72);
      chk("R7 clear bit1 ignores 6:4", pc_out, 8'hD8);

      // R10 reads of control address and idle bus
      bus_rd(2'd3, r); chk("R10 control read", r, 8'h00);
      @(negedge clk); addr = 2'd0; sel_n = 1'b1; rd_n = 1'b0; #1 chk("R10 idle sel_n high", rdata, 8'h00);
      rd_n = 1'b1; sel_n = 1'b0; #1 chk("R10 idle rd_n high", rdata, 8'h00);
      sel_n = 1'b1;

      // R11 suppressed writes on every address
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd0, 8'h11); bus_wr(2'd1, 8'h22); bus_wr(2'd2, 8'h33);
      for (int a = 0; a < 4; a++) begin
         bus_wr(2'(a), (a == 3) ? 8'h9B : 8'hEE, 1'b1, 1'b0);
         bus_wr(2'(a), (a == 3) ? 8'h01 : 8'hEE, 1'b0, 1'b1);
      end
      check_state("R11 suppressed writes");

      // R1 reset after activity
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0; model_reset();
      check_state("R1 second reset");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule